// File: doc/BRIEF.md
# Triggered Readout Packet Builder

This block records the per-crossing data of a trigger processor in a rolling history and turns an accept pulse into a readout packet. Each clock is one bunch crossing. On every clock the block writes the crossing's trigger objects, expanded (64-bit) trigger objects and raw input samples into the history, tagged with a 12-bit crossing number. When `accept` is high, the entry written `cfg_latency` crossings earlier is copied into a derandomising FIFO. The copy carries the event number and the section flags decided at that moment. A packing state machine then drains the FIFO one event at a time and emits 64-bit words on a valid/ready/last stream.

Every packet has the same layout. The trigger objects are always included. The expanded objects are added when `cfg_xtob_en` was set at accept time. The raw samples are added when `cfg_raw_en` was set and no raw deadtime was running. Each raw readout starts a programmable deadtime, so raw input can be held to a small fraction of the accept rate. When the FIFO occupancy reaches a programmable level, `busy` rises. An accept that meets a full FIFO is dropped and counted as lost.

The packer has six states:
- IDLE goes to HEAD when the FIFO holds an event.
- HEAD goes to TOB on a handshake.
- TOB steps through the object slots. After the last slot it goes to XTOB if that flag is set, otherwise to RAW if that flag is set, otherwise to TRAIL.
- XTOB steps through its slots, then goes to RAW or TRAIL.
- RAW steps through its slots, then goes to TRAIL.
- TRAIL pops the FIFO on a handshake and returns to IDLE.

Top module: `trig_readout_packer`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_last` and `busy` are 0 and `lost_cnt` is 0. After reset is released, the first crossing written has crossing id 0 and the first accept gets event number 0.
- R2: An accept in crossing c captures the data presented in crossing c−`cfg_latency` (latency 1 to 255). The header carries that crossing's id, which counts one per clock from reset and wraps at 4096.
- R3: A packet is these words in order: a header, then one word per trigger-object slot (slot 0 first, object in bits 31:0, upper bits zero), then the optional sections, then a trailer. Header layout: bits 63:56 = 0xE7, bits 55:44 = crossing id, bits 43:20 = event number, bit 1 = raw section present, bit 0 = expanded section present, all other bits 0.
- R4: The expanded section is N_XTOB words, slot 0 first, each a full 64-bit expanded object. It is present exactly when `cfg_xtob_en` was 1 in the accept's crossing. Later changes of `cfg_xtob_en` do not alter events already captured.
- R5: The raw section is N_RAW 64-bit words, slot 0 first. It follows any expanded section. It is present when `cfg_raw_en` is 1 at a captured accept and the deadtime counter is zero. A raw readout loads the counter with `cfg_deadtime`, and the counter drops by one per crossing. So after a raw readout in crossing c, accepts up to crossing c+`cfg_deadtime` carry no raw section and an accept in crossing c+`cfg_deadtime`+1 can.
- R6: The trailer has bits 63:56 = 0x7E, bits 15:0 = number of words in the packet (header and trailer included), all other bits 0. `out_last` is high on the trailer only.
- R7: The event number increments on every accept, including lost ones. A dropped event therefore leaves a gap in the event numbers of the packets that follow.
- R8: An accept that arrives while the FIFO holds FIFO_DEPTH events is not captured and increments `lost_cnt` one clock later.
- R9: `busy` is 1 exactly when the number of events in the FIFO (captured and not yet finished by a trailer handshake) is at least `cfg_afull`.
- R10: Packets leave in accept order. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xing_tob | input | 64 | Trigger-object slots of this crossing, slot k in bits 32k+31:32k |
| xing_xtob | input | 128 | Expanded-object slots of this crossing, 64 bits each |
| xing_raw | input | 128 | Raw input sample words of this crossing, 64 bits each |
| accept | input | 1 | Readout accept for this crossing |
| cfg_latency | input | 8 | Capture latency in crossings, 1 to 255 |
| cfg_xtob_en | input | 1 | Include expanded objects |
| cfg_raw_en | input | 1 | Include raw input when the deadtime allows |
| cfg_deadtime | input | 16 | Raw readout deadtime in crossings |
| cfg_afull | input | 4 | FIFO occupancy at which busy rises |
| out_data | output | 64 | Packet word |
| out_valid | output | 1 | Word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_last | output | 1 | Word is the trailer |
| busy | output | 1 | FIFO at or above the almost-full level |
| lost_cnt | output | 16 | Accepts dropped on a full FIFO, wrapping |

## Verification
A wrong history pointer or latency offset shows at the first packet after an accept. The header's crossing id and the object words no longer match what the bench presented `cfg_latency` crossings earlier. A wrong FIFO count or a lost pop shows within one clock: `busy` disagrees with the bench's count of open events, or `lost_cnt` moves at the wrong accept. A packer slip shows on the next handshake as a misplaced word, a wrong trailer count or a stray `out_last`. A deadtime error shows on the second accept inside or just past the window, as a raw flag and raw section that should not be there, or a missing one.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int WORD_W = 64;
    localparam logic [7:0] HEAD_TAG = 8'hE7;
    localparam logic [7:0] TAIL_TAG = 8'h7E;

    typedef enum logic [2:0] {
        PK_IDLE,
        PK_HEAD,
        PK_TOB,
        PK_XTOB,
        PK_RAW,
        PK_TRAIL
    } pk_state_t;

    // header: tag, crossing id, event number, section flags
    function automatic logic [WORD_W-1:0] make_header(
        input logic [11:0] xid,
        input logic [23:0] evt,
        input logic        raw_on,
        input logic        xtob_on
    );
        return {HEAD_TAG, xid, evt, 18'd0, raw_on, xtob_on};
    endfunction

    function automatic logic [WORD_W-1:0] make_trailer(input logic [15:0] nwords);
        return {TAIL_TAG, 40'd0, nwords};
    endfunction

endpackage

// File: rtl/rob_history.sv
module rob_history #(
    parameter int LAT_W  = 8,
    parameter int BC_W   = 12,
    parameter int DATA_W = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LAT_W-1:0]  lat,
    output logic [DATA_W-1:0] rd_data,
    output logic [BC_W-1:0]   rd_bc
);
    localparam int DEPTH = 1 << LAT_W;
    localparam int ENT_W = DATA_W + BC_W;

    logic [LAT_W-1:0] wr_ptr;
    logic [LAT_W-1:0] rd_ptr;
    logic [BC_W-1:0]  bc_now;
    logic [ENT_W-1:0] ring [DEPTH];

    // scrolling pointer and crossing id advance once per crossing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            bc_now <= '0;
        end else begin
            wr_ptr <= wr_ptr + 1'b1;
            bc_now <= bc_now + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        ring[wr_ptr] <= {bc_now, wr_data};
    end

    assign rd_ptr = wr_ptr - lat;
    assign {rd_bc, rd_data} = ring[rd_ptr];

    // R2
    lat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat != '0);

endmodule

// File: rtl/rob_capture.sv
module rob_capture #(
    parameter int DT_W   = 16,
    parameter int EVT_W  = 24,
    parameter int LOST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              fifo_full,
    input  logic              cfg_raw_en,
    input  logic [DT_W-1:0]   cfg_deadtime,
    output logic              push,
    output logic              raw_grant,
    output logic [EVT_W-1:0]  evt_num,
    output logic [LOST_W-1:0] lost_cnt
);
    logic [DT_W-1:0] dead_left;

    assign push      = accept && !fifo_full;
    assign raw_grant = push && cfg_raw_en && (dead_left == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_num   <= '0;
            lost_cnt  <= '0;
            dead_left <= '0;
        end else begin
            if (accept) begin
                evt_num <= evt_num + 1'b1;
            end
            if (accept && fifo_full) begin
                lost_cnt <= lost_cnt + 1'b1;
            end
            if (raw_grant) begin
                dead_left <= cfg_deadtime;
            end else if (dead_left != '0) begin
                dead_left <= dead_left - 1'b1;
            end
        end
    end

    // R5
    raw_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_grant && (cfg_deadtime != '0) |=> !raw_grant);

endmodule

// File: rtl/rob_fifo.sv
module rob_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wp;
    logic [PTR_W-1:0] rp;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wp <= bump(wp);
            end
            if (pop) begin
                rp <= bump(rp);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wp] <= wdata;
        end
    end

    assign rdata = slots[rp];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/rob_packer.sv
module rob_packer
    import rob_pkg::*;
#(
    parameter int N_TOB  = 2,
    parameter int TOB_W  = 32,
    parameter int N_XTOB = 2,
    parameter int N_RAW  = 2,
    parameter int BC_W   = 12,
    parameter int EVT_W  = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ev_valid,
    input  logic [BC_W-1:0]          ev_bc,
    input  logic [EVT_W-1:0]         ev_evt,
    input  logic                     ev_x,
    input  logic                     ev_r,
    input  logic [N_TOB*TOB_W-1:0]   ev_tob,
    input  logic [N_XTOB*WORD_W-1:0] ev_xtob,
    input  logic [N_RAW*WORD_W-1:0]  ev_raw,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [WORD_W-1:0]        out_data,
    output logic                     out_last,
    output logic                     pop
);
    localparam int MAX_A = (N_TOB > N_XTOB) ? N_TOB : N_XTOB;
    localparam int MAX_N = (MAX_A > N_RAW) ? MAX_A : N_RAW;
    localparam int IDX_W = $clog2(MAX_N + 1);

    pk_state_t        st, st_nxt;
    logic [IDX_W-1:0] idx, idx_nxt;
    logic [15:0]      word_total;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PK_IDLE;
            idx <= '0;
        end else begin
            st  <= st_nxt;
            idx <= idx_nxt;
        end
    end

    // transitions
    always_comb begin
        st_nxt  = st;
        idx_nxt = idx;
        unique case (st)
            PK_IDLE: begin
                if (ev_valid) begin
                    st_nxt  = PK_HEAD;
                    idx_nxt = '0;
                end
            end
            PK_HEAD: begin
                if (out_ready) begin
                    st_nxt  = PK_TOB;
                    idx_nxt = '0;
                end
            end
            PK_TOB: begin
                if (out_ready) begin
                    if (idx == IDX_W'(N_TOB - 1)) begin
                        idx_nxt = '0;
                        st_nxt  = ev_x ? PK_XTOB : (ev_r ? PK_RAW : PK_TRAIL);
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
            end
            PK_XTOB: begin
                if (out_ready) begin
                    if (idx == IDX_W'(N_XTOB - 1)) begin
                        idx_nxt = '0;
                        st_nxt  = ev_r ? PK_RAW : PK_TRAIL;
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
            end
            PK_RAW: begin
                if (out_ready) begin
                    if (idx == IDX_W'(N_RAW - 1)) begin
                        idx_nxt = '0;
                        st_nxt  = PK_TRAIL;
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
            end
            PK_TRAIL: begin
                if (out_ready) begin
                    st_nxt = PK_IDLE;
                end
            end
            default: st_nxt = PK_IDLE;
        endcase
    end

    assign word_total = 16'(2 + N_TOB)
                      + (ev_x ? 16'(N_XTOB) : 16'd0)
                      + (ev_r ? 16'(N_RAW) : 16'd0);

    // outputs
    always_comb begin
        out_valid = (st != PK_IDLE);
        out_last  = (st == PK_TRAIL);
        pop       = (st == PK_TRAIL) && out_ready;
        out_data  = '0;
        unique case (st)
            PK_HEAD:  out_data = make_header(12'(ev_bc), 24'(ev_evt), ev_r, ev_x);
            PK_TOB:   out_data = WORD_W'(ev_tob[int'(idx)*TOB_W +: TOB_W]);
            PK_XTOB:  out_data = ev_xtob[int'(idx)*WORD_W +: WORD_W];
            PK_RAW:   out_data = ev_raw[int'(idx)*WORD_W +: WORD_W];
            PK_TRAIL: out_data = make_trailer(word_total);
            default:  out_data = '0;
        endcase
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6
    trail_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);

endmodule

// File: rtl/trig_readout_packer.sv
module trig_readout_packer
    import rob_pkg::*;
#(
    parameter int N_TOB      = 2,
    parameter int TOB_W      = 32,
    parameter int N_XTOB     = 2,
    parameter int N_RAW      = 2,
    parameter int LAT_W      = 8,
    parameter int BC_W       = 12,
    parameter int EVT_W      = 24,
    parameter int DT_W       = 16,
    parameter int LOST_W     = 16,
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_TOB*TOB_W-1:0]   xing_tob,
    input  logic [N_XTOB*WORD_W-1:0] xing_xtob,
    input  logic [N_RAW*WORD_W-1:0]  xing_raw,
    input  logic                     accept,
    input  logic [LAT_W-1:0]         cfg_latency,
    input  logic                     cfg_xtob_en,
    input  logic                     cfg_raw_en,
    input  logic [DT_W-1:0]          cfg_deadtime,
    input  logic [CNT_W-1:0]         cfg_afull,
    output logic [WORD_W-1:0]        out_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     out_last,
    output logic                     busy,
    output logic [LOST_W-1:0]        lost_cnt
);
    localparam int TOBV_W = N_TOB * TOB_W;
    localparam int XV_W   = N_XTOB * WORD_W;
    localparam int RV_W   = N_RAW * WORD_W;
    localparam int SNAP_W = TOBV_W + XV_W + RV_W;
    localparam int PAY_W  = BC_W + EVT_W + 2 + SNAP_W;

    logic [SNAP_W-1:0] snap;
    logic [BC_W-1:0]   snap_bc;
    logic              push, raw_grant, pop;
    logic [EVT_W-1:0]  evt_num;
    logic [PAY_W-1:0]  fifo_wdata, fifo_rdata;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full, fifo_empty;

    logic [BC_W-1:0]   h_bc;
    logic [EVT_W-1:0]  h_evt;
    logic              h_x, h_r;
    logic [TOBV_W-1:0] h_tob;
    logic [XV_W-1:0]   h_xtob;
    logic [RV_W-1:0]   h_raw;

    rob_history #(
        .LAT_W  (LAT_W),
        .BC_W   (BC_W),
        .DATA_W (SNAP_W)
    ) u_history (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data ({xing_tob, xing_xtob, xing_raw}),
        .lat     (cfg_latency),
        .rd_data (snap),
        .rd_bc   (snap_bc)
    );

    rob_capture #(
        .DT_W   (DT_W),
        .EVT_W  (EVT_W),
        .LOST_W (LOST_W)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .fifo_full    (fifo_full),
        .cfg_raw_en   (cfg_raw_en),
        .cfg_deadtime (cfg_deadtime),
        .push         (push),
        .raw_grant    (raw_grant),
        .evt_num      (evt_num),
        .lost_cnt     (lost_cnt)
    );

    assign fifo_wdata = {snap_bc, evt_num, cfg_xtob_en, raw_grant, snap};

    rob_fifo #(
        .W     (PAY_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (fifo_wdata),
        .pop   (pop),
        .rdata (fifo_rdata),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    assign {h_bc, h_evt, h_x, h_r, h_tob, h_xtob, h_raw} = fifo_rdata;
    assign busy = (fifo_cnt >= cfg_afull);

    rob_packer #(
        .N_TOB  (N_TOB),
        .TOB_W  (TOB_W),
        .N_XTOB (N_XTOB),
        .N_RAW  (N_RAW),
        .BC_W   (BC_W),
        .EVT_W  (EVT_W)
    ) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (!fifo_empty),
        .ev_bc     (h_bc),
        .ev_evt    (h_evt),
        .ev_x      (h_x),
        .ev_r      (h_r),
        .ev_tob    (h_tob),
        .ev_xtob   (h_xtob),
        .ev_raw    (h_raw),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .pop       (pop)
    );

    // R8
    lost_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && fifo_full |=> fifo_cnt <= $past(fifo_cnt));

endmodule

// File: tb/test_trig_readout_packer.sv
module test_trig_readout_packer;
    localparam int NT = 2;
    localparam int TW = 32;
    localparam int NX = 2;
    localparam int NR = 2;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n;
    logic [NT*TW-1:0] xing_tob;
    logic [NX*64-1:0] xing_xtob;
    logic [NR*64-1:0] xing_raw;
    logic            accept;
    logic [7:0]      cfg_latency;
    logic            cfg_xtob_en, cfg_raw_en;
    logic [15:0]     cfg_deadtime;
    logic [3:0]      cfg_afull;
    logic [63:0]     out_data;
    logic            out_valid, out_ready, out_last, busy;
    logic [15:0]     lost_cnt;

    trig_readout_packer i_trig_readout_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .xing_tob     (xing_tob),
        .xing_xtob    (xing_xtob),
        .xing_raw     (xing_raw),
        .accept       (accept),
        .cfg_latency  (cfg_latency),
        .cfg_xtob_en  (cfg_xtob_en),
        .cfg_raw_en   (cfg_raw_en),
        .cfg_deadtime (cfg_deadtime),
        .cfg_afull    (cfg_afull),
        .out_data     (out_data),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_last     (out_last),
        .busy         (busy),
        .lost_cnt     (lost_cnt)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    int rmode = 1;

    // reference model state
    logic [64:0]      exp_q[$];
    string            tag_q[$];
    logic [NT*TW-1:0] h_tob [256];
    logic [NX*64-1:0] h_x   [256];
    logic [NR*64-1:0] h_r   [256];
    int bc = 0;
    int evt = 0;
    int m_cnt = 0;
    int dt = 0;
    int lost = 0;
    bit prev_hold = 0;
    logic [63:0] prev_data = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] mix(input int n, input int salt);
        logic [31:0] a, b;
        a = 32'(n) * 32'h9E3779B1 + 32'(salt) * 32'h01000193;
        b = 32'(n) ^ (32'(salt) << 20) ^ 32'h5A5A0000;
        return {a, b};
    endfunction

    task automatic qpush(input bit last, input logic [63:0] w, input string t);
        exp_q.push_back({last, w});
        tag_q.push_back(t);
    endtask

    // one crossing: compare outputs, advance model for the coming edge, wait
    task automatic step();
        logic [64:0] e;
        string tg;
        bit full_now, rg;
        int s, cb, nw;
        chk(busy == (m_cnt >= int'(cfg_afull)), "R9 busy", 64'(busy), 64'(m_cnt >= int'(cfg_afull)));
        chk(lost_cnt == 16'(lost), "R8 lost count", 64'(lost_cnt), 64'(lost));
        if (prev_hold) chk(out_valid && out_data == prev_data, "R10 hold", out_data, prev_data);
        if (out_valid && exp_q.size() == 0) chk(0, "R10 word with nothing pending", out_data, 64'd0);
        full_now = (m_cnt >= DEPTH);
        if (out_valid && out_ready && exp_q.size() != 0) begin
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            chk(out_data == e[63:0] && out_last == e[64], tg, out_data, e[63:0]);
            if (e[64]) m_cnt--;
        end
        rg = 0;
        if (accept) begin
            if (full_now) begin
                lost++;
            end else begin
                rg = cfg_raw_en && (dt == 0);
                s  = (bc - int'(cfg_latency)) & 255;
                cb = (bc - int'(cfg_latency)) & 4095;
                qpush(0, {8'hE7, 12'(cb), 24'(evt), 18'd0, rg, cfg_xtob_en}, "R1 R2 R3 R7 header");
                nw = 2 + NT;
                for (int k = 0; k < NT; k++) qpush(0, 64'(h_tob[s][k*TW +: TW]), "R2 R3 tob word");
                if (cfg_xtob_en) begin
                    for (int k = 0; k < NX; k++) qpush(0, h_x[s][k*64 +: 64], "R4 xtob word");
                    nw += NX;
                end
                if (rg) begin
                    for (int k = 0; k < NR; k++) qpush(0, h_r[s][k*64 +: 64], "R5 raw word");
                    nw += NR;
                end
                qpush(1, {8'h7E, 40'd0, 16'(nw)}, "R6 trailer");
                m_cnt++;
            end
            evt++;
        end
        if (rg) dt = int'(cfg_deadtime);
        else if (dt > 0) dt--;
        h_tob[bc & 255] = xing_tob;
        h_x[bc & 255]   = xing_xtob;
        h_r[bc & 255]   = xing_raw;
        bc++;
        prev_hold = out_valid && !out_ready;
        prev_data = out_data;
        @(negedge clk);
    endtask

    task automatic cyc(input bit acc);
        logic [63:0] t;
        accept = acc;
        out_ready = (rmode == 1) || (rmode == 2 && (bc % 2) == 0);
        for (int k = 0; k < NT; k++) begin
            t = mix(bc, k);
            xing_tob[k*TW +: TW] = t[31:0];
        end
        for (int k = 0; k < NX; k++) xing_xtob[k*64 +: 64] = mix(bc, 10 + k);
        for (int k = 0; k < NR; k++) xing_raw[k*64 +: 64] = mix(bc, 20 + k);
        step();
    endtask

    initial begin
        rst_n = 0; accept = 0; out_ready = 0;
        cfg_latency = 8'd5; cfg_xtob_en = 0; cfg_raw_en = 0;
        cfg_deadtime = '0; cfg_afull = 4'd6;
        xing_tob = '0; xing_xtob = '0; xing_raw = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_valid == 0, "R1 reset valid", 64'(out_valid), 64'd0);
        chk(out_last == 0, "R1 reset last", 64'(out_last), 64'd0);
        chk(busy == 0, "R1 reset busy", 64'(busy), 64'd0);
        chk(lost_cnt == 0, "R1 reset lost", 64'(lost_cnt), 64'd0);
        rst_n = 1;
        rmode = 1;
        repeat (260) cyc(0);
        // R2 R3 plain packet
        cfg_latency = 8'd5;
        cyc(1);
        repeat (20) cyc(0);
        // R5 deadtime window edges, R4 expanded section
        cfg_latency = 8'd1; cfg_xtob_en = 1; cfg_raw_en = 1; cfg_deadtime = 16'd20;
        cyc(1);
        repeat (19) cyc(0);
        cyc(1);
        cyc(1);
        repeat (40) cyc(0);
        // R2 longest latency
        cfg_latency = 8'd255; cfg_raw_en = 0;
        cyc(1);
        repeat (30) cyc(0);
        // R4 R5 flags fixed at accept time
        cfg_latency = 8'd7; cfg_xtob_en = 1; cfg_raw_en = 1; cfg_deadtime = 16'd0;
        rmode = 0;
        cyc(1);
        cfg_xtob_en = 0; cfg_raw_en = 0;
        repeat (5) cyc(0);
        rmode = 1;
        repeat (30) cyc(0);
        // R8 R9 R10 backpressure, overflow, stalls
        cfg_latency = 8'd3; cfg_xtob_en = 1; cfg_raw_en = 1; cfg_deadtime = 16'd2;
        rmode = 0;
        repeat (10) cyc(1);
        repeat (3) cyc(0);
        rmode = 2;
        repeat (200) cyc(0);
        rmode = 1;
        for (int n = 0; n < 2000 && (exp_q.size() != 0 || out_valid); n++) cyc(0);
        chk(exp_q.size() == 0, "R10 all packets delivered", 64'(exp_q.size()), 64'd0);
        chk(lost == 2, "R8 two accepts dropped", 64'(lost), 64'd2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule